// File: doc/BRIEF.md
# Serial Flag-Offset Register Chain

This block keeps the almost-empty and almost-full threshold offsets for every queue of a multi-queue FIFO. The offsets sit on parallel outputs that the flag comparators read. Software or a test controller reprograms them one bit per clock through a single serial chain, and it can read them back through that same chain. A strobe loads one of four preset thresholds into every register at once. A mode input halves the chain, so that only the lower half of the queues is programmed.

A write only takes effect once the whole chain has been clocked in. The new values then reach the outputs together, and a one-cycle done pulse marks the moment. A read first copies the live registers into a private scan copy and streams from that copy, least significant bit first. Once the copy is empty, further read clocks give zeros. A second set of enable and data inputs lets a test-access instruction decoder drive the chain in place of the dedicated pins. The serial output serves both paths.

Top module: `sofs_chain`

## Requirements
- R1: While rst_n is low, every offset register holds preset 0 (DEF_0). `ser_out`, `clash_err` and `load_done` are 0.
- R2: When `ld_def` is high on a clock edge, every offset register takes the preset chosen by `def_sel` (0 to DEF_0, 1 to DEF_1, 2 to DEF_2, 3 to DEF_3). The write bit count returns to zero, so the next write starts at chain bit 0.
- R3: Each write clock stores the data bit at the next chain position. Position k maps to bit (k mod OFS_W) of a register. Registers run in the order: queue 0 almost-empty, queue 0 almost-full, queue 1 almost-empty, and so on. All written registers update together on the edge that stores the last bit of the active chain. `load_done` is high for exactly the one cycle after that edge.
- R4: A partial write, or clocks without a write, leave the parallel offset outputs unchanged.
- R5: While a read is enabled, the n-th consecutive read edge puts chain bit n-1 on `ser_out`. Ending the read drives `ser_out` to 0, and the next read starts again at bit 0.
- R6: A read streams the values the registers held at its first edge. Register changes during the read do not alter the stream.
- R7: After the whole active chain has been read, further read edges give 0 on `ser_out`.
- R8: A write request together with a read request on the same edge shifts nothing, reads nothing and moves no counter. `clash_err` is high in the following cycle.
- R9: With `dual_mode` high, the active chain is half as long and covers only the lower half of the queues. The upper queues keep their values on commit, and a read gives zeros after the half-length chain.
- R10: With `tap_sel` high, `tap_si`, `tap_wr` and `tap_rd` (active high) drive the chain. The dedicated pins have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Dedicated serial data in |
| swen_n | input | 1 | Dedicated write enable, active low |
| sren_n | input | 1 | Dedicated read enable, active low |
| def_sel | input | 2 | Preset choice for ld_def |
| ld_def | input | 1 | Load preset into all registers |
| dual_mode | input | 1 | Half-length chain, lower queues only |
| tap_sel | input | 1 | Hand the chain to the test-access path |
| tap_si | input | 1 | Test-access serial data in |
| tap_wr | input | 1 | Test-access write request, active high |
| tap_rd | input | 1 | Test-access read request, active high |
| ser_out | output | 1 | Serial read data, shared by both paths |
| clash_err | output | 1 | Write and read requested together last cycle |
| load_done | output | 1 | One-cycle pulse after a full chain commit |
| ae_ofs | output | NUM_Q*OFS_W | Almost-empty offsets, queue 0 in the low bits |
| af_ofs | output | NUM_Q*OFS_W | Almost-full offsets, queue 0 in the low bits |

## Verification
The bench builds the block with four queues and 5-bit offsets, which gives a 40-bit chain in quad mode and a 20-bit chain in dual mode. With chains this short, full commits, read-back past the end, restarted reads and a clash in the middle of a write all fit in a few hundred cycles. The bench also overrides the presets with four distinct values that fit in 5 bits, so each `def_sel` code gives an output it can tell apart from the others.

// File: rtl/sofs_pkg.sv
package sofs_pkg;

   // Operation requested on the chain in the current cycle
   typedef enum logic [1:0] {
      SRC_IDLE  = 2'd0,
      SRC_WRITE = 2'd1,
      SRC_READ  = 2'd2,
      SRC_CLASH = 2'd3
   } sofs_op_e;

   function automatic int unsigned chain_bits(int unsigned nq, int unsigned w);
      return 2 * nq * w;
   endfunction

endpackage

// File: rtl/sofs_src_mux.sv
module sofs_src_mux
   import sofs_pkg::*;
(
   input  logic     swen_n,
   input  logic     sren_n,
   input  logic     ser_in,
   input  logic     tap_sel,
   input  logic     tap_si,
   input  logic     tap_wr,
   input  logic     tap_rd,
   output sofs_op_e op,
   output logic     bit_in
);

   logic wr_req;
   logic rd_req;

   always_comb begin
      if (tap_sel) begin
         wr_req = tap_wr;
         rd_req = tap_rd;
         bit_in = tap_si;
      end else begin
         wr_req = ~swen_n;
         rd_req = ~sren_n;
         bit_in = ser_in;
      end
   end

   always_comb begin
      unique case ({wr_req, rd_req})
         2'b10:   op = SRC_WRITE;
         2'b01:   op = SRC_READ;
         2'b11:   op = SRC_CLASH;
         default: op = SRC_IDLE;
      endcase
   end

endmodule

// File: rtl/sofs_load_chain.sv
module sofs_load_chain
   import sofs_pkg::*;
#(
   parameter int unsigned NUM_Q = 4,
   parameter int unsigned OFS_W = 16,
   parameter int unsigned DEF_0 = 7,
   parameter int unsigned DEF_1 = 63,
   parameter int unsigned DEF_2 = 127,
   parameter int unsigned DEF_3 = 1023,
   localparam int unsigned CHAIN = chain_bits(NUM_Q, OFS_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_def,
   input  logic [1:0]       def_sel,
   input  logic             dual_mode,
   input  sofs_op_e         op,
   input  logic             bit_in,
   output logic [CHAIN-1:0] live,
   output logic             done
);

   localparam int unsigned HALF = CHAIN / 2;
   localparam int unsigned CW   = $clog2(CHAIN);
   localparam int unsigned NREG = 2 * NUM_Q;
   localparam logic [CW-1:0] LAST_QUAD = CW'(CHAIN - 1);
   localparam logic [CW-1:0] LAST_DUAL = CW'(HALF - 1);
   localparam logic [OFS_W-1:0] P0 = OFS_W'(DEF_0);

   logic [CHAIN-1:0] live_r;
   logic [CHAIN-1:0] stage_r;
   logic [CW-1:0]    cnt_r;
   logic             done_r;
   logic [OFS_W-1:0] def_word;
   logic [CHAIN-1:0] def_vec;
   logic [CHAIN-1:0] rst_vec;
   logic             last_bit;

   always_comb begin
      unique case (def_sel)
         2'd0:    def_word = OFS_W'(DEF_0);
         2'd1:    def_word = OFS_W'(DEF_1);
         2'd2:    def_word = OFS_W'(DEF_2);
         default: def_word = OFS_W'(DEF_3);
      endcase
   end

   // Every register of the chain gets the same preset word
   for (genvar r = 0; r < NREG; r++) begin : g_def
      assign def_vec[r*OFS_W +: OFS_W] = def_word;
      assign rst_vec[r*OFS_W +: OFS_W] = P0;
   end

   assign last_bit = (cnt_r == (dual_mode ? LAST_DUAL : LAST_QUAD));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_r  <= rst_vec;
         stage_r <= '0;
         cnt_r   <= '0;
         done_r  <= 1'b0;
      end else begin
         done_r <= 1'b0;
         if (ld_def) begin
            live_r <= def_vec;
            cnt_r  <= '0;
         end else if (op == SRC_WRITE) begin
            stage_r[cnt_r] <= bit_in;
            if (last_bit) begin
               cnt_r  <= '0;
               done_r <= 1'b1;
               for (int i = 0; i < CHAIN; i++) begin
                  if (!dual_mode || i < HALF)
                     live_r[i] <= (i == int'(cnt_r)) ? bit_in : stage_r[i];
               end
            end else begin
               cnt_r <= cnt_r + 1'b1;
            end
         end
      end
   end

   assign live = live_r;
   assign done = done_r;

endmodule

// File: rtl/sofs_readback.sv
module sofs_readback
   import sofs_pkg::*;
#(
   parameter int unsigned NUM_Q = 4,
   parameter int unsigned OFS_W = 16,
   localparam int unsigned CHAIN = chain_bits(NUM_Q, OFS_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dual_mode,
   input  sofs_op_e         op,
   input  logic [CHAIN-1:0] live,
   output logic             so
);

   localparam int unsigned HALF = CHAIN / 2;
   localparam logic [CHAIN-1:0] LOW_MASK = {{HALF{1'b0}}, {HALF{1'b1}}};

   logic [CHAIN-1:0] snap_r;
   logic [CHAIN-1:0] seed;
   logic             active_r;
   logic             so_r;

   // Bits outside the active chain are cleared so the tail reads as zero
   assign seed = dual_mode ? (live & LOW_MASK) : live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_r   <= '0;
         active_r <= 1'b0;
         so_r     <= 1'b0;
      end else if (op == SRC_READ) begin
         active_r <= 1'b1;
         if (!active_r) begin
            so_r   <= seed[0];
            snap_r <= seed >> 1;
         end else begin
            so_r   <= snap_r[0];
            snap_r <= snap_r >> 1;
         end
      end else begin
         active_r <= 1'b0;
         so_r     <= 1'b0;
      end
   end

   assign so = so_r;

endmodule

// File: rtl/sofs_chain.sv
module sofs_chain
   import sofs_pkg::*;
#(
   parameter int unsigned NUM_Q = 4,
   parameter int unsigned OFS_W = 16,
   parameter int unsigned DEF_0 = 7,
   parameter int unsigned DEF_1 = 63,
   parameter int unsigned DEF_2 = 127,
   parameter int unsigned DEF_3 = 1023
) (
   input  logic                   sclk,
   input  logic                   rst_n,
   input  logic                   ser_in,
   input  logic                   swen_n,
   input  logic                   sren_n,
   input  logic [1:0]             def_sel,
   input  logic                   ld_def,
   input  logic                   dual_mode,
   input  logic                   tap_sel,
   input  logic                   tap_si,
   input  logic                   tap_wr,
   input  logic                   tap_rd,
   output logic                   ser_out,
   output logic                   clash_err,
   output logic                   load_done,
   output logic [NUM_Q*OFS_W-1:0] ae_ofs,
   output logic [NUM_Q*OFS_W-1:0] af_ofs
);

   localparam int unsigned CHAIN = chain_bits(NUM_Q, OFS_W);
   localparam int unsigned PAIR  = 2 * OFS_W;

   // Elaboration-time parameter checks
   if (NUM_Q < 2 || (NUM_Q % 2) != 0) begin : g_bad_nq
      $error("sofs_chain: NUM_Q must be even and at least 2");
   end
   if (OFS_W < 2 || OFS_W > 31) begin : g_bad_w
      $error("sofs_chain: OFS_W must lie in 2..31");
   end
   if (DEF_0 >= (1 << OFS_W) || DEF_1 >= (1 << OFS_W) ||
       DEF_2 >= (1 << OFS_W) || DEF_3 >= (1 << OFS_W)) begin : g_bad_def
      $error("sofs_chain: a preset does not fit in OFS_W bits");
   end

   sofs_op_e         op_w;
   logic             bit_w;
   logic [CHAIN-1:0] live_w;
   logic             clash_r;

   sofs_src_mux u_src (
      .swen_n (swen_n),
      .sren_n (sren_n),
      .ser_in (ser_in),
      .tap_sel(tap_sel),
      .tap_si (tap_si),
      .tap_wr (tap_wr),
      .tap_rd (tap_rd),
      .op     (op_w),
      .bit_in (bit_w)
   );

   sofs_load_chain #(
      .NUM_Q(NUM_Q), .OFS_W(OFS_W),
      .DEF_0(DEF_0), .DEF_1(DEF_1), .DEF_2(DEF_2), .DEF_3(DEF_3)
   ) u_load (
      .clk      (sclk),
      .rst_n    (rst_n),
      .ld_def   (ld_def),
      .def_sel  (def_sel),
      .dual_mode(dual_mode),
      .op       (op_w),
      .bit_in   (bit_w),
      .live     (live_w),
      .done     (load_done)
   );

   sofs_readback #(
      .NUM_Q(NUM_Q), .OFS_W(OFS_W)
   ) u_rd (
      .clk      (sclk),
      .rst_n    (rst_n),
      .dual_mode(dual_mode),
      .op       (op_w),
      .live     (live_w),
      .so       (ser_out)
   );

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) clash_r <= 1'b0;
      else        clash_r <= (op_w == SRC_CLASH);
   end
   assign clash_err = clash_r;

   // Per-queue split of the chain into the two threshold buses
   for (genvar q = 0; q < NUM_Q; q++) begin : g_q
      assign ae_ofs[q*OFS_W +: OFS_W] = live_w[q*PAIR +: OFS_W];
      assign af_ofs[q*OFS_W +: OFS_W] = live_w[q*PAIR + OFS_W +: OFS_W];
   end

endmodule

// File: rtl/sofs_chain_chk.sv
module sofs_chain_chk
   import sofs_pkg::*;
#(
   parameter int unsigned NUM_Q = 4,
   parameter int unsigned OFS_W = 16
) (
   input logic                   sclk,
   input logic                   rst_n,
   input logic                   ld_def,
   input sofs_op_e               op,
   input logic                   ser_out,
   input logic                   clash_err,
   input logic                   load_done,
   input logic [NUM_Q*OFS_W-1:0] ae_ofs,
   input logic [NUM_Q*OFS_W-1:0] af_ofs
);

   // R8
   clash_flag_chk: assert property (@(posedge sclk) disable iff (!rst_n)
      (op == SRC_CLASH) |=> clash_err);

   // R8
   clash_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n)
      (op == SRC_CLASH && !ld_def) |=> ($stable(ae_ofs) && $stable(af_ofs)));

   // R5
   idle_out_chk: assert property (@(posedge sclk) disable iff (!rst_n)
      (op != SRC_READ) |=> (ser_out == 1'b0));

   // R3
   done_pulse_chk: assert property (@(posedge sclk) disable iff (!rst_n)
      load_done |=> !load_done);

   // R3
   done_cause_chk: assert property (@(posedge sclk) disable iff (!rst_n)
      (op != SRC_WRITE) |=> !load_done);

   // R4
   hold_chk: assert property (@(posedge sclk) disable iff (!rst_n)
      !ld_def |=> (($stable(ae_ofs) && $stable(af_ofs)) || load_done));

endmodule

bind sofs_chain sofs_chain_chk #(.NUM_Q(NUM_Q), .OFS_W(OFS_W)) u_chk (
   .sclk     (sclk),
   .rst_n    (rst_n),
   .ld_def   (ld_def),
   .op       (op_w),
   .ser_out  (ser_out),
   .clash_err(clash_err),
   .load_done(load_done),
   .ae_ofs   (ae_ofs),
   .af_ofs   (af_ofs)
);

// File: tb/sofs_chain_tb.sv
module sofs_chain_tb;

   localparam int NQ = 4;
   localparam int W  = 5;
   localparam int CH = 2 * NQ * W;   // 40
   localparam int HF = CH / 2;       // 20
   localparam int D0 = 3, D1 = 9, D2 = 17, D3 = 30;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_in = 1'b0, swen_n = 1'b1, sren_n = 1'b1;
   logic [1:0] def_sel = 2'd2;
   logic ld_def = 1'b0, dual_mode = 1'b0;
   logic tap_sel = 1'b0, tap_si = 1'b0, tap_wr = 1'b0, tap_rd = 1'b0;
   logic ser_out, clash_err, load_done;
   logic [NQ*W-1:0] ae_ofs, af_ofs;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   sofs_chain #(.NUM_Q(NQ), .OFS_W(W), .DEF_0(D0), .DEF_1(D1), .DEF_2(D2), .DEF_3(D3)) u_dut (
      .sclk(sclk_w), .rst_n(rst_n), .ser_in(ser_in), .swen_n(swen_n), .sren_n(sren_n),
      .def_sel(def_sel), .ld_def(ld_def), .dual_mode(dual_mode), .tap_sel(tap_sel),
      .tap_si(tap_si), .tap_wr(tap_wr), .tap_rd(tap_rd), .ser_out(ser_out),
      .clash_err(clash_err), .load_done(load_done), .ae_ofs(ae_ofs), .af_ofs(af_ofs));

   wire sclk_w = clk;

   // ---------------- behavioural reference model ----------------
   logic [63:0] m_live, m_stage, m_snap;
   int m_wcnt, m_rptr;
   bit m_reading, m_so, m_err, m_done;

   function automatic logic [63:0] rep(int v);
      logic [63:0] r = '0;
      for (int i = 0; i < 2 * NQ; i++) r[i*W +: W] = v[W-1:0];
      return r;
   endfunction

   function automatic int pick(logic [1:0] s);
      return (s == 0) ? D0 : (s == 1) ? D1 : (s == 2) ? D2 : D3;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_live = rep(D0); m_stage = '0; m_snap = '0;
         m_wcnt = 0; m_rptr = 0; m_reading = 0; m_so = 0; m_err = 0; m_done = 0;
      end else begin
         bit wr, rd, b;
         int len;
         logic [63:0] old;
         wr  = tap_sel ? tap_wr : !swen_n;
         rd  = tap_sel ? tap_rd : !sren_n;
         b   = tap_sel ? tap_si : ser_in;
         len = dual_mode ? HF : CH;
         old = m_live;
         m_err = wr && rd;
         m_done = 0;
         if (ld_def) begin
            m_live = rep(pick(def_sel));
            m_wcnt = 0;
         end else if (wr && !rd) begin
            m_stage[m_wcnt] = b;
            if (m_wcnt == len - 1) begin
               for (int i = 0; i < len; i++) m_live[i] = m_stage[i];
               m_wcnt = 0;
               m_done = 1;
            end else m_wcnt++;
         end
         if (rd && !wr) begin
            if (!m_reading) begin m_snap = old; m_rptr = 0; m_reading = 1; end
            m_so = (m_rptr < len) ? m_snap[m_rptr] : 1'b0;
            if (m_rptr < len) m_rptr++;
         end else begin
            m_reading = 0;
            m_so = 0;
         end
      end
   end

   function automatic logic [NQ*W-1:0] m_ae();
      logic [NQ*W-1:0] r;
      for (int q = 0; q < NQ; q++) r[q*W +: W] = m_live[q*2*W +: W];
      return r;
   endfunction

   function automatic logic [NQ*W-1:0] m_af();
      logic [NQ*W-1:0] r;
      for (int q = 0; q < NQ; q++) r[q*W +: W] = m_live[q*2*W + W +: W];
      return r;
   endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R5 ser_out", 64'(ser_out), 64'(m_so));
         chk("R8 clash_err", 64'(clash_err), 64'(m_err));
         chk("R3 load_done", 64'(load_done), 64'(m_done));
         chk("R4 ae_ofs", 64'(ae_ofs), 64'(m_ae()));
         chk("R4 af_ofs", 64'(af_ofs), 64'(m_af()));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_def(logic [1:0] s);
      @(negedge clk); def_sel = s; ld_def = 1'b1;
      @(negedge clk); ld_def = 1'b0;
   endtask

   task automatic write_bits(logic [63:0] v, int from, int upto, bit ext);
      for (int k = from; k < upto; k++) begin
         @(negedge clk);
         if (ext) begin tap_wr = 1'b1; tap_si = v[k]; end
         else begin swen_n = 1'b0; ser_in = v[k]; end
      end
      @(negedge clk);
      swen_n = 1'b1; tap_wr = 1'b0;
   endtask

   task automatic read_bits(int n, bit ext, output logic [63:0] got);
      got = '0;
      @(negedge clk);
      if (ext) tap_rd = 1'b1; else sren_n = 1'b0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         got[k] = ser_out;
      end
      sren_n = 1'b1; tap_rd = 1'b0;
   endtask

   function automatic logic [NQ*W-1:0] ae_of(logic [63:0] v);
      logic [NQ*W-1:0] r;
      for (int q = 0; q < NQ; q++) r[q*W +: W] = v[q*2*W +: W];
      return r;
   endfunction

   function automatic logic [NQ*W-1:0] af_of(logic [63:0] v);
      logic [NQ*W-1:0] r;
      for (int q = 0; q < NQ; q++) r[q*W +: W] = v[q*2*W + W +: W];
      return r;
   endfunction

   function automatic logic [63:0] pattern(int seed);
      logic [63:0] r = '0;
      for (int q = 0; q < NQ; q++) begin
         r[q*2*W +: W]     = W'(seed + 3 * q + 1);
         r[q*2*W + W +: W] = W'(31 - seed - q);
      end
      return r;
   endfunction

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
   end

   initial begin
      logic [63:0] pa, pb, pc, pd, got;
      logic [63:0] mixed;
      pa = pattern(0); pb = pattern(5); pc = pattern(9); pd = pattern(2);

      // R1: reset state uses preset 0 regardless of def_sel
      idle(2);
      chk("R1 ser_out in reset", 64'(ser_out), 0);
      chk("R1 load_done in reset", 64'(load_done), 0);
      chk("R1 ae in reset", 64'(ae_ofs), 64'(ae_of(rep(D0))));
      @(negedge clk); rst_n = 1'b1;
      idle(1);
      chk("R1 ae after reset", 64'(ae_ofs), 64'(ae_of(rep(D0))));
      chk("R1 clash_err after reset", 64'(clash_err), 0);

      // R2: each preset code
      for (int s = 0; s < 4; s++) begin
         pulse_def(2'(s));
         chk("R2 ae preset", 64'(ae_ofs), 64'(ae_of(rep(pick(2'(s))))));
         chk("R2 af preset", 64'(af_ofs), 64'(af_of(rep(pick(2'(s))))));
      end

      // R4 then R3: partial write holds, last bit commits
      write_bits(pa, 0, CH - 1, 0);
      chk("R4 partial write ae", 64'(ae_ofs), 64'(ae_of(rep(D3))));
      @(negedge clk); swen_n = 1'b0; ser_in = pa[CH-1];
      @(negedge clk); swen_n = 1'b1;
      chk("R3 done pulse", 64'(load_done), 1);
      chk("R3 ae after commit", 64'(ae_ofs), 64'(ae_of(pa)));
      chk("R3 af after commit", 64'(af_ofs), 64'(af_of(pa)));

      // R5 and R7: full read-back then zero tail
      read_bits(CH + 8, 0, got);
      chk("R5 read stream", got & ((64'd1 << CH) - 1), pa);
      chk("R7 zero tail", got >> CH, 0);

      // R5: a restarted read begins at bit 0
      read_bits(3, 0, got);
      chk("R5 restart first", got, pa & 64'h7);
      read_bits(3, 0, got);
      chk("R5 restart second", got, pa & 64'h7);

      // R6: preset load during a read leaves the stream alone
      got = '0;
      @(negedge clk); sren_n = 1'b0;
      for (int k = 0; k < CH; k++) begin
         @(negedge clk);
         got[k] = ser_out;
         if (k == 9) begin ld_def = 1'b1; def_sel = 2'd3; end
         if (k == 10) ld_def = 1'b0;
      end
      sren_n = 1'b1;
      chk("R6 stream from copy", got, pa);
      chk("R6 live took preset", 64'(ae_ofs), 64'(ae_of(rep(D3))));

      // R8: clash alone, then clash in the middle of a write
      @(negedge clk); swen_n = 1'b0; sren_n = 1'b0; ser_in = 1'b1;
      @(negedge clk); swen_n = 1'b1; sren_n = 1'b1;
      chk("R8 clash flag", 64'(clash_err), 1);
      chk("R8 clash no read", 64'(ser_out), 0);
      write_bits(pb, 0, 5, 0);
      @(negedge clk); swen_n = 1'b0; sren_n = 1'b0; ser_in = ~pb[5];
      @(negedge clk); swen_n = 1'b1; sren_n = 1'b1;
      write_bits(pb, 5, CH, 0);
      chk("R8 write unaffected ae", 64'(ae_ofs), 64'(ae_of(pb)));
      chk("R8 write unaffected af", 64'(af_ofs), 64'(af_of(pb)));

      // R2: preset load restarts a partial write at bit 0
      write_bits(pd, 0, 7, 0);
      pulse_def(2'd1);
      write_bits(pa, 0, CH, 0);
      chk("R2 count cleared", 64'(ae_ofs), 64'(ae_of(pa)));

      // R9: dual mode half chain
      pulse_def(2'd0);
      @(negedge clk); dual_mode = 1'b1;
      write_bits(pc, 0, HF, 0);
      mixed = (rep(D0) & ~((64'd1 << HF) - 1)) | (pc & ((64'd1 << HF) - 1));
      chk("R9 dual ae", 64'(ae_ofs), 64'(ae_of(mixed)));
      chk("R9 dual af", 64'(af_ofs), 64'(af_of(mixed)));
      read_bits(HF + 4, 0, got);
      chk("R9 dual read", got & ((64'd1 << HF) - 1), pc & ((64'd1 << HF) - 1));
      chk("R9 dual zero tail", got >> HF, 0);
      @(negedge clk); dual_mode = 1'b0;

      // R10: test-access path, dedicated pins ignored
      @(negedge clk); tap_sel = 1'b1; sren_n = 1'b0; swen_n = 1'b0; ser_in = 1'b1;
      @(negedge clk);
      chk("R10 dedicated read ignored", 64'(ser_out), 0);
      chk("R10 dedicated clash ignored", 64'(clash_err), 0);
      sren_n = 1'b1; swen_n = 1'b1;
      write_bits(pd, 0, CH, 1);
      chk("R10 tap write ae", 64'(ae_ofs), 64'(ae_of(pd)));
      read_bits(CH, 1, got);
      chk("R10 tap read", got, pd);
      @(negedge clk); tap_sel = 1'b0;
      idle(3);

      summary();
   end

endmodule